// File: doc/BRIEF.md
# Registered Four-Kind Shift Unit

This block is the shift execution stage of a small load-store processor. It takes a 32-bit operand, a 5-bit immediate count and the low five bits of a count register, and produces the operand shifted by one of four kinds: logical right, arithmetic right, logical left, or left rotate. The result appears one clock after a request strobe, together with a valid flag.

The shift amount is the immediate field whenever that field is nonzero. A zero immediate selects the register count instead. A count of zero always means no shift; it never stands for a shift of 32. Register reads, opcode decoding and writeback belong to neighbouring blocks.

A small controller has two states. IDLE moves to LOADED on a request (the transition is named CAPTURE). LOADED stays in LOADED on a new request (RELOAD) and returns to IDLE without one (DRAIN). The valid flag is high only in LOADED.

Top module: `shift_unit`

## Requirements
- R1: A synchronous reset forces the valid output low on the next clock edge. After reset the controller is in IDLE.
- R2: The count is `imm_cnt` when `imm_cnt` is nonzero. When `imm_cnt` is zero, the count is `reg_cnt`.
- R3: Kind code 2'b00 selects logical right shift: the top n bits become zero, and the low 32-n bits are operand bits 31..n.
- R4: Kind code 2'b01 selects arithmetic right shift: the top n bits are copies of operand bit 31. For example, 0x97EAEC16 shifted by 13 gives 0xFFFCBF57.
- R5: Kind code 2'b10 selects left shift: operand bits 31-n..0 move up, and n zeros fill the bottom.
- R6: Kind code 2'b11 selects rotate left: operand bits 31..32-n wrap around into the low n positions.
- R7: When the count is zero, every kind returns the operand unchanged.
- R8: When `req` is high at a clock edge, `valid` is high after that edge and `result` holds the shift of the inputs sampled at that edge.
- R9: When `req` is low at a clock edge, `valid` is low after that edge and `result` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req | input | 1 | Request strobe |
| kind | input | 2 | Shift kind: 00 logical right, 01 arithmetic right, 10 left, 11 rotate left |
| operand | input | 32 | Value to be shifted |
| imm_cnt | input | 5 | Immediate count field |
| reg_cnt | input | 5 | Low five bits of the count register |
| result | output | 32 | Registered shift result |
| valid | output | 1 | Result valid, one cycle after a request |

## Verification
The hardest case to reach from the ports is the count-source override. The register count must be ignored whenever the immediate field is nonzero, and the immediate must fall back cleanly to the register count when it is zero. The stimulus sweeps all 32 counts through both paths. When the immediate path is used, the register count is driven with a deliberately different, nonzero value, so a wrong selection changes the result. Back-to-back requests keep the controller in LOADED to exercise the RELOAD transition. The sign fill and the wrap-around are checked at counts 1 and 31.

// File: rtl/shift_pkg.sv
package shift_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned CNT_W  = $clog2(DATA_W);

    typedef enum logic [1:0] {
        KIND_SRL = 2'b00,
        KIND_SRA = 2'b01,
        KIND_SLL = 2'b10,
        KIND_ROL = 2'b11
    } shift_kind_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_LOADED = 1'b1
    } ctrl_state_e;
endpackage

// File: rtl/shift_count_sel.sv
module shift_count_sel #(
    parameter int unsigned CW = 5
) (
    input  logic [CW-1:0] imm_cnt,
    input  logic [CW-1:0] reg_cnt,
    output logic [CW-1:0] amount
);
    // The immediate field wins unless it is zero; zero hands over to the register count.
    always_comb begin
        if (imm_cnt != '0) amount = imm_cnt;
        else               amount = reg_cnt;
    end

    always_comb begin
        assert_src_choice_R2: assert ((imm_cnt == '0) || (amount == imm_cnt));
    end
endmodule

// File: rtl/shift_core.sv
module shift_core
    import shift_pkg::*;
#(
    parameter int unsigned W  = 32,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic [1:0]    kind,
    input  logic [W-1:0]  din,
    input  logic [CW-1:0] amount,
    output logic [W-1:0]  dout
);
    // Log-depth shifter. Every shift is done as a rotate left, then a mask picks
    // which positions keep the rotated bits and which take the fill bit.
    logic          right;
    logic [W-1:0]  rev_in;
    logic [W-1:0]  stage [CW+1];
    logic [W-1:0]  rot_out;
    logic [W-1:0]  keep_mask;
    logic [W-1:0]  fill_v;
    logic          fill_bit;

    assign right = (kind == KIND_SRL) || (kind == KIND_SRA);

    // A right shift is a left shift of the bit-reversed operand.
    generate
        for (genvar i = 0; i < W; i++) begin : g_rev
            assign rev_in[i] = din[W-1-i];
        end
    endgenerate

    assign stage[0] = right ? rev_in : din;

    // One rotate stage per count bit.
    generate
        for (genvar s = 0; s < CW; s++) begin : g_stage
            localparam int unsigned SH = 1 << s;
            assign stage[s+1] = amount[s]
                ? {stage[s][W-1-SH:0], stage[s][W-1:W-SH]}
                : stage[s];
        end
    endgenerate

    generate
        for (genvar i = 0; i < W; i++) begin : g_unrev
            assign rot_out[i] = right ? stage[CW][W-1-i] : stage[CW][i];
        end
    endgenerate

    always_comb begin
        logic [W-1:0] low_ones;
        low_ones = ({W{1'b1}} << amount);
        unique case (kind)
            KIND_SRL, KIND_SRA: keep_mask = ~({W{1'b1}} >> amount) ^ {W{1'b1}};
            KIND_SLL:           keep_mask = low_ones;
            default:            keep_mask = {W{1'b1}};
        endcase
    end

    assign fill_bit = (kind == KIND_SRA) ? din[W-1] : 1'b0;
    assign fill_v   = {W{fill_bit}};
    assign dout     = (rot_out & keep_mask) | (fill_v & ~keep_mask);

    always_comb begin
        assert_zero_pass_R7: assert ((amount != '0) || (dout == din));
        assert_rot_ones_R6:  assert ((kind != KIND_ROL) || ($countones(dout) == $countones(din)));
    end
endmodule

// File: rtl/shift_ctrl.sv
module shift_ctrl
    import shift_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic load,
    output logic busy_valid
);
    ctrl_state_e state_q, state_d;

    // State register.
    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    // Next-state logic: CAPTURE, RELOAD and DRAIN.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (req) state_d = ST_LOADED;
            ST_LOADED: state_d = req ? ST_LOADED : ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // Output logic.
    always_comb begin
        load       = req;
        busy_valid = (state_q == ST_LOADED);
    end

    assert_req_valid_R8: assert property (@(posedge clk) disable iff (rst)
        req |=> busy_valid);
    assert_noreq_idle_R9: assert property (@(posedge clk) disable iff (rst)
        !req |=> !busy_valid);
endmodule

// File: rtl/shift_unit.sv
module shift_unit
    import shift_pkg::*;
#(
    parameter int unsigned W  = DATA_W,
    parameter int unsigned CW = $clog2(W)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          req,
    input  logic [1:0]    kind,
    input  logic [W-1:0]  operand,
    input  logic [CW-1:0] imm_cnt,
    input  logic [CW-1:0] reg_cnt,
    output logic [W-1:0]  result,
    output logic          valid
);
    logic [CW-1:0] amount;
    logic [W-1:0]  shifted;
    logic          load;
    logic [W-1:0]  result_q;

    shift_count_sel #(.CW(CW)) u_sel (
        .imm_cnt (imm_cnt),
        .reg_cnt (reg_cnt),
        .amount  (amount)
    );

    shift_core #(.W(W), .CW(CW)) u_core (
        .kind   (kind),
        .din    (operand),
        .amount (amount),
        .dout   (shifted)
    );

    shift_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .req        (req),
        .load       (load),
        .busy_valid (valid)
    );

    always_ff @(posedge clk) begin
        if (load) result_q <= shifted;
    end
    assign result = result_q;

    assert_reset_clear_R1: assert property (@(posedge clk) rst |=> !valid);
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !req |=> $stable(result));
endmodule

// File: tb/shift_unit_tb_top.sv
module shift_unit_tb_top;
    logic        clk = 1'b0;
    logic        rst;
    logic        req;
    logic [1:0]  kind;
    logic [31:0] operand;
    logic [4:0]  imm_cnt;
    logic [4:0]  reg_cnt;
    logic [31:0] result;
    logic        valid;
    int          n_chk = 0;
    int          n_bad = 0;

    always #2.5 clk = ~clk;

    shift_unit dut_i (
        .clk(clk), .rst(rst), .req(req), .kind(kind), .operand(operand),
        .imm_cnt(imm_cnt), .reg_cnt(reg_cnt), .result(result), .valid(valid)
    );

    // Directed vectors: {kind, operand, imm, reg, expected}
    localparam int NV = 10;
    localparam logic [75:0] VEC [NV] = '{
        {2'b01, 32'h97EAEC16, 5'd13, 5'd0,  32'hFFFCBF57},
        {2'b00, 32'h97EAEC16, 5'd13, 5'd0,  32'h0004BF57},
        {2'b00, 32'h80000000, 5'd31, 5'd3,  32'h00000001},
        {2'b01, 32'h80000000, 5'd31, 5'd3,  32'hFFFFFFFF},
        {2'b10, 32'h00000001, 5'd31, 5'd7,  32'h80000000},
        {2'b11, 32'h80000001, 5'd1,  5'd9,  32'h00000003},
        {2'b11, 32'h12345678, 5'd0,  5'd8,  32'h34567812},
        {2'b10, 32'hFFFFFFFF, 5'd0,  5'd4,  32'hFFFFFFF0},
        {2'b01, 32'hF0000000, 5'd0,  5'd0,  32'hF0000000},
        {2'b11, 32'hDEADBEEF, 5'd0,  5'd0,  32'hDEADBEEF}
    };

    function automatic logic [31:0] model(input logic [1:0] k, input logic [31:0] d,
                                          input int n);
        logic [63:0] sx;
        case (k)
            2'b00:   return d >> n;
            2'b01:   begin sx = {{32{d[31]}}, d}; return sx[31:0] >> 0 == 0 ? (sx >> n) : (sx >> n); end
            2'b10:   return d << n;
            default: return (n == 0) ? d : ((d << n) | (d >> (32 - n)));
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [1:0] k, input logic [31:0] d,
                         input logic [4:0] im, input logic [4:0] rg);
        @(negedge clk);
        req = 1'b1; kind = k; operand = d; imm_cnt = im; reg_cnt = rg;
        @(negedge clk);
    endtask

    initial begin
        #400000;
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] last;
        rst = 1'b1; req = 1'b0; kind = '0; operand = '0; imm_cnt = '0; reg_cnt = '0;
        repeat (3) @(negedge clk);
        check("R1 reset valid", {31'b0, valid}, 32'd0);
        rst = 1'b0;

        for (int i = 0; i < NV; i++) begin
            issue(VEC[i][75:74], VEC[i][73:42], VEC[i][41:37], VEC[i][36:32]);
            check("R3 R4 R5 R6 R7 vector", result, VEC[i][31:0]);
            check("R8 valid", {31'b0, valid}, 32'd1);
        end

        // Sweep all counts through both sources and all kinds (R2).
        for (int k = 0; k < 4; k++) begin
            for (int n = 0; n < 32; n++) begin
                logic [31:0] d;
                d = $urandom();
                if (n != 0) begin
                    issue(k[1:0], d, n[4:0], 5'(n ^ 5'h15 | 1));
                    check("R2 immediate count", result, model(k[1:0], d, n));
                end
                issue(k[1:0], d, 5'd0, n[4:0]);
                check("R2 register count", result, model(k[1:0], d, n));
            end
        end

        // No request: valid drops and result holds (R9).
        last = result;
        req = 1'b0; operand = 32'h55555555; imm_cnt = 5'd3;
        @(negedge clk);
        check("R9 valid low", {31'b0, valid}, 32'd0);
        check("R9 result hold", result, last);

        // Reset mid-stream (R1).
        issue(2'b10, 32'h1, 5'd1, 5'd0);
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0; req = 1'b0;
        check("R1 reset clears valid", {31'b0, valid}, 32'd0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule